// File: doc/BRIEF.md
# Parallel Port Strobe Handshake Controller

This block is a small register-mapped parallel I/O unit with three ports. Output port B has its own strobe line, port C is an 8-bit bidirectional port with a direction register and an input capture latch, and the strobe input paces the transfers. A control register chooses one of three modes. In simple strobed mode, port C values are captured on a strobe edge and every port B write emits a strobe pulse. Full-input handshake mode captures port C and uses the outgoing strobe to acknowledge reads. Full-output handshake mode drives port C and uses the outgoing strobe to announce new data.

The strobe input passes through a synchronizer, and its active edge is chosen by a control bit. Each active edge sets a status flag, which can raise an interrupt. The flag clears only through a two-step access. Software first reads the control register while the flag is set. It then accesses the port C latch address: a read in the input modes, or a write in full-output mode. The outgoing strobe is either a fixed two-cycle pulse or a level that holds until the next active input edge. Pin drivers appear only as per-bit output-enable signals.

Top module: `pport_hs`

## Requirements
- R1: Register addresses are 0 = control/status, 1 = port B data, 2 = port C (read returns the capture latch, write sets the port C output data), 3 = port C direction (1 = output). Control layout: bit7 = flag (read only), bit6 = interrupt enable, bits5:4 = mode (00 simple strobed, 01 full-input handshake, 10 full-output handshake, 11 acts as simple), bit3 = edge select (1 rising, 0 falling), bit2 = STRB style (1 pulse, 0 level), bits1:0 read 0. After reset all registers read 0, and `portc_oe`, `strb_o`, `irq` and `portb_o` are 0.
- R2: In simple and full-input modes, each active edge of `stra_i` copies `portc_i` into the latch and sets the flag. An edge of the opposite polarity changes neither the latch nor the flag.
- R3: In full-output mode an active edge sets the flag and leaves the latch unchanged.
- R4: In the input modes the flag clears only after a control read taken while the flag is 1, followed by a port C read. A port C read without that prior control read leaves the flag at 1.
- R5: In full-output mode the flag clears only after a control read taken while the flag is 1, followed by a port C write. A port C read in this mode does not clear it.
- R6: `irq` is 1 exactly while the flag and the interrupt enable are both 1.
- R7: In simple mode each port B write updates `portb_o` and produces a high pulse on `strb_o` that lasts exactly 2 clock cycles, whatever the STRB style bit.
- R8: In both handshake modes a port B write updates `portb_o` and leaves `strb_o` low.
- R9: In a handshake mode with pulse style, a port C read (full-input) or port C write (full-output) produces a 2-cycle high pulse on `strb_o`.
- R10: In a handshake mode with level style, the same access raises `strb_o`. It stays high until the next active `stra_i` edge, then drops.
- R11: In full-output mode, `portc_oe` is all ones while the synchronized `stra_i` sits at its active level (high for rising, low for falling), and equals the direction register otherwise. In the other modes `portc_oe` always equals the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| portb_o | output | 8 | Port B output data |
| strb_o | output | 1 | Outgoing strobe, active high |
| stra_i | input | 1 | Incoming strobe, asynchronous |
| portc_i | input | 8 | Port C pin values |
| portc_o | output | 8 | Port C output data |
| portc_oe | output | 8 | Port C per-bit output enable |

## Verification
Random capture rounds pick a random edge polarity and random pin data. Each round then gives an opposite-polarity edge with fresh pin data, which shows whether the edge select is honoured and whether the latch really holds. Directed sequences try the clear access out of order and with the wrong kind of port C access, which shows that the two-step clear depends on the mode. The outgoing strobe is observed across several cycles after port B writes and port C accesses in every mode and style. This separates a 2-cycle pulse, no pulse at all, and a level that waits for the next incoming edge. The output enable is sampled with the incoming strobe both active and inactive, and across modes.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int PP_DW = 8;
    localparam int PP_AW = 2;

    localparam logic [PP_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [PP_AW-1:0] ADDR_PB   = 2'd1;
    localparam logic [PP_AW-1:0] ADDR_PC   = 2'd2;
    localparam logic [PP_AW-1:0] ADDR_DDR  = 2'd3;

    typedef enum logic [1:0] {
        MODE_SIMPLE = 2'b00,
        MODE_FIN    = 2'b01,
        MODE_FOUT   = 2'b10,
        MODE_RSVD   = 2'b11
    } pp_mode_e;

    typedef struct packed {
        logic     ie;
        pp_mode_e mode;
        logic     rise;
        logic     pulse;
    } pp_ctrl_t;

    function automatic logic pp_is_hs(pp_mode_e m);
        return (m == MODE_FIN) || (m == MODE_FOUT);
    endfunction

    function automatic logic pp_captures(pp_mode_e m);
        return m != MODE_FOUT;
    endfunction

endpackage

// File: rtl/pport_stra_edge.sv
module pport_stra_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stra_i,
    input  logic rise_sel,
    output logic lvl_o,
    output logic edge_o
);
    localparam int ST = (STAGES < 2) ? 2 : STAGES;

    logic [ST-1:0] sync_q;
    logic          prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[ST-2:0], stra_i};
            prev_q <= sync_q[ST-1];
        end
    end

    assign lvl_o  = sync_q[ST-1];
    assign edge_o = rise_sel ? (lvl_o & ~prev_q) : (~lvl_o & prev_q);
endmodule

// File: rtl/pport_strb_gen.sv
module pport_strb_gen #(
    parameter int PULSE_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_trig,
    input  logic level_set,
    input  logic level_clr,
    output logic strb_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LEN = CW'(PULSE_LEN);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            if (pulse_trig)
                cnt_q <= LEN;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            if (level_set)
                lvl_q <= 1'b1;
            else if (level_clr)
                lvl_q <= 1'b0;
        end
    end

    assign strb_o = (cnt_q != '0) | lvl_q;
endmodule

// File: rtl/pport_hs.sv
module pport_hs
    import pport_pkg::*;
#(
    parameter int DW          = PP_DW,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_LEN   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          irq,
    output logic [DW-1:0] portb_o,
    output logic          strb_o,
    input  logic          stra_i,
    input  logic [DW-1:0] portc_i,
    output logic [DW-1:0] portc_o,
    output logic [DW-1:0] portc_oe
);
    pp_ctrl_t      ctrl_q;
    logic          flag_q, armed_q;
    logic [DW-1:0] latch_q, portb_q, portc_q, ddr_q;
    logic          stra_lvl, act_edge, stra_act;
    logic          is_hs, is_fout, is_simple;
    logic          pc_rd, pc_wr, ctrl_rd, latch_acc, flag_clr;
    logic          pulse_trig, level_set;

    pport_stra_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .stra_i   (stra_i),
        .rise_sel (ctrl_q.rise),
        .lvl_o    (stra_lvl),
        .edge_o   (act_edge)
    );

    assign is_hs     = pp_is_hs(ctrl_q.mode);
    assign is_fout   = (ctrl_q.mode == MODE_FOUT);
    assign is_simple = !is_hs;
    assign stra_act  = ctrl_q.rise ? stra_lvl : ~stra_lvl;

    assign ctrl_rd   = rd_en && (addr == ADDR_CTRL);
    assign pc_rd     = rd_en && (addr == ADDR_PC);
    assign pc_wr     = wr_en && (addr == ADDR_PC);
    assign latch_acc = is_fout ? pc_wr : pc_rd;
    assign flag_clr  = armed_q && latch_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
            latch_q <= '0;
            portb_q <= '0;
            portc_q <= '0;
            ddr_q   <= '0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    ADDR_CTRL: ctrl_q  <= pp_ctrl_t'(wr_data[6:2]);
                    ADDR_PB:   portb_q <= wr_data;
                    ADDR_PC:   portc_q <= wr_data;
                    ADDR_DDR:  ddr_q   <= wr_data;
                    default:   ;
                endcase
            end
            if (act_edge && pp_captures(ctrl_q.mode))
                latch_q <= portc_i;
            if (act_edge)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
            if (flag_clr)
                armed_q <= 1'b0;
            else if (ctrl_rd && flag_q)
                armed_q <= 1'b1;
        end
    end

    assign pulse_trig = (is_simple && wr_en && (addr == ADDR_PB))
                      || (is_hs && latch_acc && ctrl_q.pulse);
    assign level_set  = is_hs && latch_acc && !ctrl_q.pulse;

    pport_strb_gen #(.PULSE_LEN(PULSE_LEN)) u_strb (
        .clk        (clk),
        .rst        (rst),
        .pulse_trig (pulse_trig),
        .level_set  (level_set),
        .level_clr  (act_edge),
        .strb_o     (strb_o)
    );

    always_comb begin
        unique case (addr)
            ADDR_CTRL: rd_data = DW'({flag_q, ctrl_q, 2'b00});
            ADDR_PB:   rd_data = portb_q;
            ADDR_PC:   rd_data = latch_q;
            default:   rd_data = ddr_q;
        endcase
    end

    assign irq      = flag_q & ctrl_q.ie;
    assign portb_o  = portb_q;
    assign portc_o  = portc_q;
    assign portc_oe = (is_fout && stra_act) ? '1 : ddr_q;
endmodule

// File: rtl/pport_hs_chk.sv
module pport_hs_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode,
    input logic          pulse_sel,
    input logic          act_edge,
    input logic          stra_act,
    input logic          flag,
    input logic          strb,
    input logic [DW-1:0] latch,
    input logic [1:0]    addr,
    input logic          rd_en,
    input logic          wr_en,
    input logic [DW-1:0] ddr,
    input logic [DW-1:0] oe
);
    logic pulse_mode;
    assign pulse_mode = (mode == 2'b00) || (mode == 2'b11) || pulse_sel;

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        act_edge |=> flag); // R2

    AST_OUT_MODE_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (act_edge && mode == 2'b10) |=> $stable(latch)); // R3

    AST_FLAG_CLEAR_ON_PC_ACCESS: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> ($past(addr) == 2'd2 && $past(rd_en || wr_en))); // R4

    AST_STRB_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        (strb && $past(strb) && pulse_mode && $past(pulse_mode)) |=> !strb); // R7

    AST_OE_FOLLOWS_DDR: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b10) |-> (oe == ddr)); // R11

    AST_OE_FULL_OUT: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && stra_act) |-> (oe == '1)); // R11
endmodule

bind pport_hs pport_hs_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (ctrl_q.mode),
    .pulse_sel (ctrl_q.pulse),
    .act_edge  (act_edge),
    .stra_act  (stra_act),
    .flag      (flag_q),
    .strb      (strb_o),
    .latch     (latch_q),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .ddr       (ddr_q),
    .oe        (portc_oe)
);

// File: tb/pport_hs_tb_top.sv
module pport_hs_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, portb_o, portc_o, portc_oe;
    logic       irq, strb_o;
    logic       stra_i = 1'b0;
    logic [7:0] portc_i = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pport_hs dut_i (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .portb_o(portb_o),
        .strb_o(strb_o), .stra_i(stra_i), .portc_i(portc_i),
        .portc_o(portc_o), .portc_oe(portc_oe)
    );

    function automatic logic [7:0] ctrl_val(logic ie, logic [1:0] m,
                                            logic rise, logic pulse);
        return {1'b0, ie, m, rise, pulse, 2'b00};
    endfunction

    function automatic logic [7:0] exp_oe(logic [1:0] m, logic rise,
                                          logic stra, logic [7:0] ddr);
        return (m == 2'b10 && (rise ? stra : !stra)) ? 8'hFF : ddr;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_stra(logic v);
        @(negedge clk);
        stra_i = v;
        idle(5);
    endtask

    task automatic count_strb(output int hi);
        hi = 0;
        for (int i = 0; i < 6; i++) begin
            #1 if (strb_o) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d, dat, old;
        logic [7:0] cv;
        logic       rise;
        int         hi;
        void'($urandom(32'h5EED_0042));
        idle(4);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        bus_rd(2'd0, d); check("R1 ctrl", d, 8'h00);
        bus_rd(2'd2, d); check("R1 latch", d, 8'h00);
        bus_rd(2'd3, d); check("R1 ddr", d, 8'h00);
        check("R1 oe", portc_oe, 8'h00);
        check("R1 strb", {7'd0, strb_o}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 portb", portb_o, 8'h00);

        // R2 random captures with random polarity in simple mode
        for (int k = 0; k < 8; k++) begin
            rise = 1'($urandom % 2);
            cv = ctrl_val(1'b0, 2'b00, rise, 1'b0);
            bus_wr(2'd0, cv);
            set_stra(!rise);
            bus_rd(2'd0, d); bus_rd(2'd2, d);
            bus_rd(2'd0, d); check("R2 flag idle", d, cv);
            dat = 8'($urandom);
            portc_i = dat;
            set_stra(rise);
            bus_rd(2'd0, d); check("R2 flag set", d, cv | 8'h80);
            bus_rd(2'd2, d); check("R2 latch", d, dat);
            bus_rd(2'd0, d); check("R4 cleared", d, cv);
            portc_i = ~dat;
            set_stra(!rise);
            bus_rd(2'd0, d); check("R2 opposite edge flag", d, cv);
            bus_rd(2'd2, d); check("R2 opposite edge latch", d, dat);
            check("R11 oe simple", portc_oe, exp_oe(2'b00, rise, stra_i, 8'h00));
        end

        // R7 simple mode port B strobe pulse (level style bit set to 0)
        bus_wr(2'd0, ctrl_val(1'b0, 2'b00, 1'b1, 1'b0));
        set_stra(1'b0);
        d = 8'($urandom);
        bus_wr(2'd1, d);
        count_strb(hi);
        check("R7 strb cycles", 8'(hi), 8'd2);
        check("R7 portb", portb_o, d);

        // R4 R6 R9 full-input, pulse style, interrupt enabled
        cv = ctrl_val(1'b1, 2'b01, 1'b1, 1'b1);
        bus_wr(2'd0, cv);
        portc_i = 8'h96;
        set_stra(1'b1);
        check("R6 irq set", {7'd0, irq}, 8'h01);
        bus_rd(2'd2, d);
        check("R2 full-input latch", d, 8'h96);
        count_strb(hi);
        check("R9 fin pulse", 8'(hi), 8'd2);
        bus_rd(2'd0, d); check("R4 flag kept after bare read", d, cv | 8'h80);
        bus_rd(2'd2, d);
        bus_rd(2'd0, d); check("R4 flag cleared", d, cv);
        check("R6 irq clear", {7'd0, irq}, 8'h00);

        // R8 port B in handshake mode
        bus_wr(2'd1, 8'h5A);
        count_strb(hi);
        check("R8 no strb", 8'(hi), 8'd0);
        check("R8 portb", portb_o, 8'h5A);

        // R11 R3 R5 R9 full-output, pulse style
        bus_wr(2'd3, 8'h0F);
        cv = ctrl_val(1'b1, 2'b10, 1'b1, 1'b1);
        bus_wr(2'd0, cv);
        set_stra(1'b1);
        check("R11 oe active", portc_oe, exp_oe(2'b10, 1'b1, 1'b1, 8'h0F));
        set_stra(1'b0);
        check("R11 oe inactive", portc_oe, exp_oe(2'b10, 1'b1, 1'b0, 8'h0F));
        bus_wr(2'd2, 8'hA5);
        count_strb(hi);
        check("R9 fout pulse", 8'(hi), 8'd2);
        check("R9 portc_o", portc_o, 8'hA5);
        bus_rd(2'd2, old);
        portc_i = 8'h3C;
        set_stra(1'b1);
        bus_rd(2'd0, d); check("R3 flag set", d, cv | 8'h80);
        bus_rd(2'd2, d); check("R3 latch held", d, old);
        bus_rd(2'd0, d); check("R5 read does not clear", d, cv | 8'h80);
        bus_wr(2'd2, 8'hC3);
        bus_rd(2'd0, d); check("R5 write clears", d, cv);
        check("R6 irq low", {7'd0, irq}, 8'h00);

        // R10 full-input, level style
        idle(4);
        bus_wr(2'd0, ctrl_val(1'b0, 2'b01, 1'b1, 1'b0));
        bus_rd(2'd2, d);
        idle(4);
        check("R10 strb held", {7'd0, strb_o}, 8'h01);
        set_stra(1'b0);
        check("R10 held past inactive edge", {7'd0, strb_o}, 8'h01);
        set_stra(1'b1);
        check("R10 dropped on active edge", {7'd0, strb_o}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule